// File: doc/BRIEF.md
# Infrared Receive Sampler and Byte Packer

This block sits behind an infrared receiver front end whose output is already demodulated: a low level means carrier is present (a pulse) and a high level means the line is quiet (a space). The line is sampled once per sample interval, which is a fixed number of clock cycles set by a parameter. This interval is also the receive resolution. Eight consecutive samples are packed into one byte, and the bytes go into a receive FIFO. Software turns the bytes back into pulse and space lengths.

Capture is gated by activity. After reset, after an idle command, or after a long quiet stretch, the block waits for the first pulse sample. That sample becomes bit 0 of the next byte. When a run of all-space bytes grows longer than a programmable limit, capture stops and the block waits for a pulse again. The host reads the byte count from a status register and then reads that many bytes from the data register. Two interrupt causes, data available and overrun, are each masked by their own enable and by a global enable.

The register map has four addresses:
- address 0, data: reading it pops one byte, and it reads 0 when the FIFO is empty;
- address 1, status;
- address 2, control, holding the enables and the write-only commands;
- address 3, space-run limit.

Top module: `ir_rx_capture`

## Requirements
- R1: After reset, status reads 0x00, control reads 0x00, the limit register reads its reset value (15), and `irq` is low.
- R2: While control bit 0 (receiver enable) is set, one line sample is taken every SAMPLE_DIV clock cycles. The first sample is taken SAMPLE_DIV cycles after the enable write.
- R3: While waiting for activity, space samples (line high) are discarded. The first pulse sample (line low) starts capture and becomes bit 0 of a new byte.
- R4: Samples are packed least significant bit first: the k-th sample of a byte lands in bit k, and a pulse is stored as 0 and a space as 1.
- R5: The status register holds the FIFO byte count in bits [5:0], the overrun flag in bit 6, and a FIFO non-empty flag in bit 7.
- R6: Each read of the data register returns the oldest stored byte and removes it, so bytes come out in capture order.
- R7: Each completed byte equal to 0xFF extends a space run, and any other byte resets the run to zero. When the run exceeds the limit register, that byte is still stored, and capture then stops and waits for a pulse.
- R8: A byte completed while the FIFO is full is dropped and sets the overrun flag. The flag stays set until a status read clears it.
- R9: `irq` = control bit 1 (global enable) AND ((control bit 2 AND FIFO non-empty) OR (control bit 3 AND overrun flag)).
- R10: Writing control with bit 6 set (the re-arm command) empties the FIFO, discards the partly filled byte and returns to waiting for a pulse.
- R11: Writing control with bit 7 set (the flush command) empties the FIFO but keeps the partly filled byte and the capture state.
- R12: Clearing receiver enable stops sampling and discards any partly filled byte. Line activity while disabled stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_line | input | 1 | Demodulated receiver output, 0 = pulse, 1 = space |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data and status reads have side effects |
| bus_addr | input | 2 | Register address: 0 data, 1 status, 2 control, 3 limit |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle `bus_rd` is high, 0 otherwise |
| irq | output | 1 | Interrupt request, level |

## Verification
The hardest situation to reach is a command landing in the middle of a byte. The FIFO has to hold a complete byte while a partial byte is in flight, and the outcome differs between re-arm (partial byte lost) and flush (partial byte kept). The stimulus task steps the line exactly once per sample interval and lets the command write take one cycle of a chosen sample period, so the sample grid stays aligned. The bench's model applies the command before that sample. Long space tails with small limits, and streams longer than the FIFO, reach the run-stop and overrun paths.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;

  typedef enum logic [1:0] {
    REG_DATA  = 2'd0,
    REG_STAT  = 2'd1,
    REG_CTRL  = 2'd2,
    REG_LIMIT = 2'd3
  } reg_addr_e;

  localparam int CMD_REARM_BIT = 6;
  localparam int CMD_FLUSH_BIT = 7;

  // control bits [3:0], bit 0 at the bottom
  typedef struct packed {
    logic ovr_ie;
    logic dav_ie;
    logic irq_en;
    logic rx_en;
  } ctrl_t;

  typedef enum logic {ST_WAIT, ST_CAPT} cap_state_e;

  // new sample enters at the top; after eight shifts the first one sits at bit 0
  function automatic logic [7:0] pack_next(logic [7:0] acc, logic s);
    return {s, acc[7:1]};
  endfunction

  function automatic logic all_space(logic [7:0] b);
    return b == 8'hFF;
  endfunction

endpackage

// File: rtl/ir_rx_tick.sv
module ir_rx_tick #(
  parameter int SAMPLE_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SAMPLE_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!en)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = en && (cnt_q == LAST);
endmodule

// File: rtl/ir_rx_packer.sv
module ir_rx_packer
  import ir_rx_pkg::*;
#(
  parameter int LIMIT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               tick,
  input  logic               line,
  input  logic               rearm,
  input  logic [LIMIT_W-1:0] limit,
  output logic               push,
  output logic [7:0]         byte_out,
  output logic               capturing
);
  localparam int RUN_W = LIMIT_W + 1;

  cap_state_e       state_q;
  logic [7:0]       acc_q;
  logic [2:0]       nbits_q;
  logic [RUN_W-1:0] run_q;

  logic [7:0]       acc_nxt;
  logic [RUN_W-1:0] run_nxt;
  logic             stop_now;
  logic             last_bit;

  assign acc_nxt   = pack_next(acc_q, line);
  assign capturing = (state_q == ST_CAPT);
  assign last_bit  = (nbits_q == 3'd7);
  assign push      = en && !rearm && tick && capturing && last_bit;
  assign byte_out  = acc_nxt;
  assign run_nxt   = all_space(acc_nxt) ? run_q + RUN_W'(1) : '0;
  assign stop_now  = run_nxt > {1'b0, limit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      acc_q   <= '0;
      nbits_q <= '0;
      run_q   <= '0;
    end else if (!en || rearm) begin
      state_q <= ST_WAIT;
      nbits_q <= '0;
      run_q   <= '0;
    end else if (tick) begin
      unique case (state_q)
        ST_WAIT: begin
          if (!line) begin
            state_q <= ST_CAPT;
            acc_q   <= acc_nxt;
            nbits_q <= 3'd1;
          end
        end
        ST_CAPT: begin
          acc_q   <= acc_nxt;
          nbits_q <= nbits_q + 3'd1;
          if (last_bit) begin
            if (stop_now) begin
              state_q <= ST_WAIT;
              run_q   <= '0;
            end else begin
              run_q   <= run_nxt;
            end
          end
        end
        default: state_q <= ST_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo #(
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [7:0]    wdata,
  input  logic          pop,
  input  logic          clear,
  output logic [7:0]    rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          drop
);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [7:0]    mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          do_push, do_pop;

  assign full    = (count_q == CW'(DEPTH));
  assign empty   = (count_q == '0);
  assign do_push = push && !full && !clear;
  assign do_pop  = pop && !empty && !clear;
  assign drop    = push && full && !clear;
  assign count   = count_q;
  assign rdata   = mem_q[rd_ptr_q];

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (clear) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end
endmodule

// File: rtl/ir_rx_capture.sv
module ir_rx_capture
  import ir_rx_pkg::*;
#(
  parameter int SAMPLE_DIV = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int LIMIT_W    = 8,
  parameter logic [LIMIT_W-1:0] LIMIT_RST = LIMIT_W'(15)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ir_line,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  reg_addr_e          addr;
  ctrl_t              ctrl_q;
  logic [LIMIT_W-1:0] limit_q;
  logic               ovr_q;

  // named internal events
  logic               ctrl_wr, limit_wr;
  logic               cmd_rearm, fifo_flush, fifo_pop, status_rd;
  logic               sample_tick, byte_push, capturing;
  logic [7:0]         byte_data, fifo_rdata, status_byte;
  logic [CNT_W-1:0]   fifo_count;
  logic               fifo_full, fifo_empty, fifo_drop;

  assign addr       = reg_addr_e'(bus_addr);
  assign ctrl_wr    = bus_wr && (addr == REG_CTRL);
  assign limit_wr   = bus_wr && (addr == REG_LIMIT);
  assign cmd_rearm  = ctrl_wr && bus_wdata[CMD_REARM_BIT];
  assign fifo_flush = ctrl_wr && (bus_wdata[CMD_FLUSH_BIT] || bus_wdata[CMD_REARM_BIT]);
  assign fifo_pop   = bus_rd && (addr == REG_DATA);
  assign status_rd  = bus_rd && (addr == REG_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      limit_q <= LIMIT_RST;
      ovr_q   <= 1'b0;
    end else begin
      if (ctrl_wr)        ctrl_q  <= ctrl_t'(bus_wdata[3:0]);
      if (limit_wr)       limit_q <= bus_wdata[LIMIT_W-1:0];
      if (fifo_drop)      ovr_q   <= 1'b1;
      else if (status_rd) ovr_q   <= 1'b0;
    end
  end

  ir_rx_tick #(.SAMPLE_DIV(SAMPLE_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (ctrl_q.rx_en),
    .tick (sample_tick)
  );

  ir_rx_packer #(.LIMIT_W(LIMIT_W)) u_packer (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ctrl_q.rx_en),
    .tick     (sample_tick),
    .line     (ir_line),
    .rearm    (cmd_rearm),
    .limit    (limit_q),
    .push     (byte_push),
    .byte_out (byte_data),
    .capturing(capturing)
  );

  ir_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .push (byte_push),
    .wdata(byte_data),
    .pop  (fifo_pop),
    .clear(fifo_flush),
    .rdata(fifo_rdata),
    .count(fifo_count),
    .full (fifo_full),
    .empty(fifo_empty),
    .drop (fifo_drop)
  );

  assign status_byte = {!fifo_empty, ovr_q, 6'(fifo_count)};

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      unique case (addr)
        REG_DATA:  bus_rdata = fifo_empty ? 8'h00 : fifo_rdata;
        REG_STAT:  bus_rdata = status_byte;
        REG_CTRL:  bus_rdata = {4'h0, ctrl_q};
        REG_LIMIT: bus_rdata = 8'(limit_q);
        default:   bus_rdata = 8'h00;
      endcase
    end
  end

  assign irq = ctrl_q.irq_en &&
               ((ctrl_q.dav_ie && !fifo_empty) || (ctrl_q.ovr_ie && ovr_q));
endmodule

// File: rtl/ir_rx_checker.sv
module ir_rx_checker #(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_tick,
  input logic             byte_push,
  input logic             capturing,
  input logic             fifo_full,
  input logic [CNT_W-1:0] fifo_count,
  input logic             fifo_flush,
  input logic             fifo_pop,
  input logic             cmd_rearm,
  input logic             status_rd,
  input logic             ovr_q,
  input logic             irq,
  input logic             irq_en,
  input logic             rx_en
);
  assert_push_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_push |-> sample_tick);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNT_W'(FIFO_DEPTH));

  assert_overrun_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_push && fifo_full && !fifo_flush) |=> ovr_q);

  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !status_rd) |=> ovr_q);

  assert_pop_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop && fifo_count != '0 && !byte_push && !fifo_flush)
      |=> fifo_count == $past(fifo_count) - 1'b1);

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);

  assert_rearm_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rearm |=> (fifo_count == '0 && !capturing));

  assert_disable_stops_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !capturing);
endmodule

bind ir_rx_capture ir_rx_checker #(
  .FIFO_DEPTH(FIFO_DEPTH),
  .CNT_W     (CNT_W)
) i_ir_rx_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .sample_tick(sample_tick),
  .byte_push  (byte_push),
  .capturing  (capturing),
  .fifo_full  (fifo_full),
  .fifo_count (fifo_count),
  .fifo_flush (fifo_flush),
  .fifo_pop   (fifo_pop),
  .cmd_rearm  (cmd_rearm),
  .status_rd  (status_rd),
  .ovr_q      (ovr_q),
  .irq        (irq),
  .irq_en     (ctrl_q.irq_en),
  .rx_en      (ctrl_q.rx_en)
);

// File: tb/test_ir_rx_capture.sv
module test_ir_rx_capture;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 8;
  localparam int DEPTH      = 16;
  localparam logic [7:0] LIM_RST = 8'd15;

  localparam logic [7:0] C_RX    = 8'h01;
  localparam logic [7:0] C_GIE   = 8'h02;
  localparam logic [7:0] C_DAV   = 8'h04;
  localparam logic [7:0] C_OVR   = 8'h08;
  localparam logic [7:0] C_REARM = 8'h40;
  localparam logic [7:0] C_FLUSH = 8'h80;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ir_line = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int failures = 0;

  logic       q_bits[$];
  logic [7:0] q_exp[$];
  logic       exp_ovr;
  logic [7:0] cur_limit;

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_rx_capture #(
    .SAMPLE_DIV(DIV), .FIFO_DEPTH(DEPTH), .LIMIT_W(8), .LIMIT_RST(LIM_RST)
  ) i_ir_rx_capture (
    .clk(clk), .rst_n(rst_n), .ir_line(ir_line),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic add_byte(logic [7:0] b);
    for (int k = 0; k < 8; k++) q_bits.push_back(b[k]);
  endtask

  task automatic add_bits(int n, logic v);
    for (int k = 0; k < n; k++) q_bits.push_back(v);
  endtask

  // independent model of the requirements: wait, capture LSB first, space run, commands
  task automatic model(int cmd_at, logic [7:0] cmd);
    logic       waiting = 1'b1;
    logic [7:0] acc = '0;
    int         n = 0;
    int         run = 0;
    q_exp.delete();
    exp_ovr = 1'b0;
    for (int i = 0; i < q_bits.size(); i++) begin
      if (i == cmd_at) begin
        q_exp.delete();
        if (cmd[6]) begin waiting = 1'b1; n = 0; run = 0; end
      end
      if (waiting) begin
        if (q_bits[i] == 1'b0) begin
          waiting = 1'b0; acc = '0; acc[0] = 1'b0; n = 1;
        end
      end else begin
        acc[n] = q_bits[i];
        n++;
        if (n == 8) begin
          if (q_exp.size() < DEPTH) q_exp.push_back(acc);
          else exp_ovr = 1'b1;
          run = (acc == 8'hFF) ? run + 1 : 0;
          n = 0;
          if (run > int'(cur_limit)) begin waiting = 1'b1; run = 0; end
        end
      end
    end
  endtask

  // one bit per sample period; optional command written inside period cmd_at
  task automatic run_stream(logic [7:0] base, int cmd_at, logic [7:0] cmd);
    bus_write(2'd2, base & 8'hFE);
    bus_write(2'd2, base | C_RX);
    for (int i = 0; i < q_bits.size(); i++) begin
      ir_line = q_bits[i];
      if (i == cmd_at) begin
        bus_write(2'd2, base | C_RX | cmd);
        repeat (DIV - 1) @(negedge clk);
      end else begin
        repeat (DIV) @(negedge clk);
      end
    end
    ir_line = 1'b1;
    bus_write(2'd2, base & 8'hFE);
    model(cmd_at, cmd);
  endtask

  task automatic drain_check(string tag);
    logic [7:0] d;
    bus_read(2'd1, d);
    check({tag, " R5 count"}, 32'(d[5:0]), 32'(q_exp.size()));
    check({tag, " R5 nonempty"}, 32'(d[7]), 32'(q_exp.size() != 0));
    check({tag, " R8 ovr"}, 32'(d[6]), 32'(exp_ovr));
    foreach (q_exp[i]) begin
      bus_read(2'd0, d);
      check({tag, " R6 data"}, 32'(d), 32'(q_exp[i]));
    end
    bus_read(2'd1, d);
    check({tag, " R8 status after drain"}, 32'(d), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20240607));
    cur_limit = LIM_RST;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(2'd1, d); check("R1 status", 32'(d), 32'h00);
    bus_read(2'd2, d); check("R1 ctrl", 32'(d), 32'h00);
    bus_read(2'd3, d); check("R1 limit", 32'(d), 32'(LIM_RST));
    check("R1 irq", 32'(irq), 32'h0);
    bus_read(2'd0, d); check("R1 empty data", 32'(d), 32'h00);

    // R12 line activity while disabled stores nothing
    for (int i = 0; i < 5 * DIV; i++) begin ir_line = i[2]; @(negedge clk); end
    ir_line = 1'b1;
    bus_read(2'd1, d); check("R12 disabled no capture", 32'(d), 32'h00);

    // R2 R4 directed LSB-first byte, R9 data-available interrupt
    q_bits.delete(); add_bits(0, 1'b1);
    q_bits.push_back(0); q_bits.push_back(1); q_bits.push_back(1); q_bits.push_back(0);
    q_bits.push_back(1); q_bits.push_back(0); q_bits.push_back(0); q_bits.push_back(1);
    run_stream(C_GIE | C_DAV, -1, 8'h00);
    check("R4 model byte", 32'(q_exp[0]), 32'h96);
    check("R9 dav irq", 32'(irq), 32'h1);
    bus_write(2'd2, C_DAV);
    check("R9 gie off", 32'(irq), 32'h0);
    bus_write(2'd2, C_GIE | C_DAV);
    drain_check("R2 R4");
    check("R9 irq after drain", 32'(irq), 32'h0);

    // R3 leading spaces discarded
    q_bits.delete(); add_bits(5, 1'b1); add_byte(8'h5A & 8'hFE); add_byte(8'h81);
    run_stream(8'h00, -1, 8'h00);
    drain_check("R3");

    // R12 partial byte discarded on disable
    q_bits.delete(); add_byte(8'h10); add_bits(1, 1'b0); add_bits(4, 1'b1);
    run_stream(8'h00, -1, 8'h00);
    drain_check("R12 partial");

    // R7 space run limit 1, then restart on a pulse
    cur_limit = 8'd1; bus_write(2'd3, cur_limit);
    q_bits.delete(); add_byte(8'h00); add_bits(48, 1'b1); add_byte(8'hA4);
    run_stream(8'h00, -1, 8'h00);
    check("R7 expected count", 32'(q_exp.size()), 32'd4);
    drain_check("R7");

    // R7 limit 0 stops after first all-space byte
    cur_limit = 8'd0; bus_write(2'd3, cur_limit);
    q_bits.delete(); add_byte(8'h7E); add_bits(30, 1'b1);
    run_stream(8'h00, -1, 8'h00);
    drain_check("R7 zero");

    // R10 re-arm mid byte
    cur_limit = 8'd255; bus_write(2'd3, cur_limit);
    q_bits.delete(); add_byte(8'h3C);
    q_bits.push_back(0); q_bits.push_back(1); q_bits.push_back(0); q_bits.push_back(1);
    add_bits(3, 1'b1); add_byte(8'h62);
    run_stream(8'h00, 12, C_REARM);
    check("R10 expected byte", 32'(q_exp[0]), 32'h62);
    drain_check("R10");

    // R11 flush mid byte keeps partial
    run_stream(8'h00, 12, C_FLUSH);
    check("R11 expected byte", 32'(q_exp[0]), 32'h7A);
    drain_check("R11");

    // R8 overrun and sticky flag, R9 overrun interrupt
    q_bits.delete();
    for (int b = 0; b < DEPTH + 3; b++) add_byte(8'($urandom) & 8'hFE);
    run_stream(C_GIE | C_OVR, -1, 8'h00);
    check("R9 ovr irq", 32'(irq), 32'h1);
    drain_check("R8");
    check("R9 ovr irq cleared", 32'(irq), 32'h0);
    bus_write(2'd2, 8'h00);

    // random streams with small limits
    for (int t = 0; t < 8; t++) begin
      int len;
      cur_limit = 8'($urandom % 4); bus_write(2'd3, cur_limit);
      q_bits.delete();
      add_bits(int'($urandom % 5), 1'b1);
      q_bits.push_back(1'b0);
      len = 20 + int'($urandom % 60);
      for (int i = 0; i < len; i++) q_bits.push_back(($urandom % 4) != 0);
      run_stream(8'h00, -1, 8'h00);
      drain_check("R7 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule